// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit host bus. A 2-bit address picks one of the counters or a shared control port. A host write to the control port carries a control word. The word's top two bits name the counter it is for. The word then either sets that counter's byte-access scheme and counting mode, or freezes a snapshot of its count for reading. Counter values are loaded and read one byte at a time. In the two-byte scheme a per-counter toggle tracks whether the next byte is the low or the high half.

Each counter has its own gate input and its own count-clock enable, which is a single-cycle tick qualifier in the `clk` domain. A counter only counts once a complete initial value has been written. It counts on each enabled tick while its gate is high, and it reloads its initial value on the tick taken at a count of one. Two counting modes are built. The rate generator pulls the output low for the one tick period in which the count is 1. The square-wave mode flips the output on every reload. All other mode codes hold the output high and never count.

Top module: `interval_timer3`

## Requirements
- R1: Address 3 is the control port. Control word bits 7:6 pick counter 0, 1 or 2. A control word whose bits 7:6 are 3 changes no counter state.
- R2: With access code 3 (control bits 5:4), the first data write stores the low byte and the second stores the high byte. The counter is marked loaded, with its count set to the new value, only when the second byte arrives.
- R3: Access code 1 stores a written byte as bits 15:8 with a zero low byte. Access code 2 stores it as bits 7:0 with a zero high byte. In both cases one write loads the counter.
- R4: In access code 3, reads give the low byte first and then the high byte, alternating. Access codes 1 and 2 return only their own byte on every read.
- R5: A read of address 3 returns 8'hFF.
- R6: A counter decrements by one only on a cycle in which its tick enable and its gate are both high and it holds a complete initial value. Otherwise the count stays unchanged.
- R7: A counter ticked at a count of 1 reloads its initial value. In the rate-generator mode (control bits 3:1 = 3'b010), the output is low exactly while the count is 1 and is high otherwise.
- R8: In the square-wave mode (control bits 3:1 = 3'b011), the output starts high after the control word and inverts at every reload.
- R9: Access code 0 captures the running count into a hold register without touching the access or counting mode. Reads return the held value until it has been fully read, and the live count after that.
- R10: After reset every output is high, every counter is unloaded with a count of zero, and every counter uses access code 3.
- R11: Any mode code other than 3'b010 and 3'b011 keeps the output high and the count frozen, even when the counter is loaded and ticked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Counter 0..2 or control port (3) |
| wdata | input | 8 | Write data byte |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe, one cycle per byte; advances the read order |
| rdata | output | 8 | Read data for the addressed port, valid while addressed |
| cnt_en | input | 3 | Per-counter count tick enable |
| gate | input | 3 | Per-counter gate |
| tout | output | 3 | Per-counter output |

## Verification
The counting path is driven with three patterns. Ticks go to one counter only, so the bench can show that the counters do not disturb each other. Ticks are also given with the gate low, and again before the second byte of a two-byte load, so the bench can tell an enable-qualified decrement from a free-running one. The readback checks use the two-byte order, the single-byte repeats and a latch taken between ticks, and these separate the held snapshot from the live count. The output checks come at the count of 1 and at each reload, which sets the rate-generator pulse apart from the square-wave toggle and from the inert modes.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int NCH    = 3;
    localparam int CW     = 16;
    localparam int AW     = 2;
    localparam int BW     = 8;
    localparam logic [AW-1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_HI    = 2'd1,
        ACC_LO    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    localparam logic [2:0] MODE_RATE   = 3'd2;
    localparam logic [2:0] MODE_SQUARE = 3'd3;

    function automatic logic is_counting(input logic [2:0] m);
        return (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction
endpackage

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
    import timer_pkg::*;
(
    input  logic [AW-1:0]  addr,
    input  logic           wr_stb,
    input  logic           rd_stb,
    input  logic [1:0]     sel,
    output logic [NCH-1:0] ctl_we,
    output logic [NCH-1:0] data_we,
    output logic [NCH-1:0] data_rd
);
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign ctl_we[i]  = wr_stb && (addr == CTL_ADDR) && (sel == 2'(i));
        assign data_we[i] = wr_stb && (addr == AW'(i));
        assign data_rd[i] = rd_stb && (addr == AW'(i));
    end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic          data_we,
    input  logic          data_rd,
    input  logic [BW-1:0] wdata,
    input  logic          tick_en,
    input  logic          gate,
    output logic [BW-1:0] rbyte,
    output logic [CW-1:0] cnt,
    output logic          tout
);
    acc_e          acc_q;
    logic [2:0]    mode_q;
    logic [CW-1:0] init_q, cnt_q, hold_q;
    logic          wtog_q, rtog_q, loaded_q, held_q, sq_q;

    acc_e          new_acc;
    logic [2:0]    new_mode;
    logic [CW-1:0] view;
    logic          run;

    assign new_acc  = acc_e'(wdata[5:4]);
    assign new_mode = wdata[3:1];
    assign view     = held_q ? hold_q : cnt_q;
    assign run      = tick_en && gate && loaded_q && is_counting(mode_q);
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= ACC_LOHI;
            mode_q   <= '0;
            init_q   <= '0;
            cnt_q    <= '0;
            hold_q   <= '0;
            wtog_q   <= 1'b0;
            rtog_q   <= 1'b0;
            loaded_q <= 1'b0;
            held_q   <= 1'b0;
            sq_q     <= 1'b1;
        end else begin
            if (ctl_we) begin
                if (new_acc == ACC_LATCH) begin
                    if (!held_q) begin
                        hold_q <= cnt_q;
                        held_q <= 1'b1;
                        rtog_q <= 1'b0;
                    end
                end else begin
                    acc_q    <= new_acc;
                    mode_q   <= new_mode;
                    wtog_q   <= 1'b0;
                    rtog_q   <= 1'b0;
                    loaded_q <= 1'b0;
                    held_q   <= 1'b0;
                    sq_q     <= 1'b1;
                end
            end else if (data_we) begin
                case (acc_q)
                    ACC_HI: begin
                        init_q   <= {wdata, 8'h00};
                        cnt_q    <= {wdata, 8'h00};
                        loaded_q <= 1'b1;
                    end
                    ACC_LO: begin
                        init_q   <= {8'h00, wdata};
                        cnt_q    <= {8'h00, wdata};
                        loaded_q <= 1'b1;
                    end
                    ACC_LOHI: begin
                        if (!wtog_q) begin
                            init_q[7:0] <= wdata;
                            wtog_q      <= 1'b1;
                        end else begin
                            init_q[15:8] <= wdata;
                            cnt_q        <= {wdata, init_q[7:0]};
                            wtog_q       <= 1'b0;
                            loaded_q     <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (run) begin
                if (cnt_q == CW'(1)) begin
                    cnt_q <= init_q;
                    sq_q  <= ~sq_q;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
            if (data_rd) begin
                case (acc_q)
                    ACC_HI, ACC_LO: held_q <= 1'b0;
                    ACC_LOHI: begin
                        rtog_q <= ~rtog_q;
                        if (rtog_q) held_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (acc_q)
            ACC_HI:   rbyte = view[15:8];
            ACC_LOHI: rbyte = rtog_q ? view[15:8] : view[7:0];
            default:  rbyte = view[7:0];
        endcase
    end

    always_comb begin
        if (!loaded_q || !is_counting(mode_q)) tout = 1'b1;
        else if (mode_q == MODE_RATE)           tout = (cnt_q != CW'(1));
        else                                    tout = sq_q;
    end
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
    import timer_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     addr,
    input  logic [7:0]     wdata,
    input  logic           wr_stb,
    input  logic           rd_stb,
    output logic [7:0]     rdata,
    input  logic [2:0]     cnt_en,
    input  logic [2:0]     gate,
    output logic [2:0]     tout
);
    logic [NCH-1:0]         ctl_we, data_we, data_rd;
    logic [BW-1:0]          rbyte [NCH];
    logic [NCH-1:0][CW-1:0] cnt_flat;

    timer_bus_decode u_dec (
        .addr    (addr),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .sel     (wdata[7:6]),
        .ctl_we  (ctl_we),
        .data_we (data_we),
        .data_rd (data_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        timer_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctl_we  (ctl_we[i]),
            .data_we (data_we[i]),
            .data_rd (data_rd[i]),
            .wdata   (wdata),
            .tick_en (cnt_en[i]),
            .gate    (gate[i]),
            .rbyte   (rbyte[i]),
            .cnt     (cnt_flat[i]),
            .tout    (tout[i])
        );
    end

    always_comb begin
        rdata = 8'hFF;
        for (int i = 0; i < NCH; i++)
            if (addr == AW'(i)) rdata = rbyte[i];
    end
endmodule

// File: rtl/interval_timer3_chk.sv
module interval_timer3_chk
    import timer_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             addr,
    input logic                   wr_stb,
    input logic [7:0]             rdata,
    input logic [2:0]             cnt_en,
    input logic [2:0]             gate,
    input logic [2:0]             tout,
    input logic [NCH-1:0][CW-1:0] cnt_flat
);
    assert_ctl_read_R5: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd3) |-> (rdata == 8'hFF));

    assert_reset_out_R10: assert property (@(posedge clk)
        rst |=> (tout == 3'b111));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (!wr_stb && (!cnt_en[i] || !gate[i])) |=> $stable(cnt_flat[i]));

        assert_step_R7: assert property (@(posedge clk) disable iff (rst)
            !wr_stb |=> ($stable(cnt_flat[i])
                         || (cnt_flat[i] == $past(cnt_flat[i]) - 16'd1)
                         || ($past(cnt_flat[i]) == 16'd1)));
    end
endmodule

bind interval_timer3 interval_timer3_chk u_chk (.*);

// File: tb/interval_timer3_test.sv
module interval_timer3_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic       wr_stb, rd_stb;
    logic [7:0] rdata;
    logic [2:0] cnt_en, gate, tout;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    interval_timer3 uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .tout(tout)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_OUT = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{OP_WR, 2'd3, 8'h34, 8'h00, 4'd1},  // R1 ch0, two-byte, rate mode
        '{OP_WR, 2'd0, 8'h05, 8'h00, 4'd2},
        '{OP_WR, 2'd0, 8'h00, 8'h00, 4'd2},
        '{OP_RD, 2'd0, 8'h00, 8'h05, 4'd4},  // R4 low first
        '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd4},
        '{OP_TK, 2'd0, 8'h01, 8'd3,  4'd6},
        '{OP_RD, 2'd0, 8'h00, 8'h02, 4'd6},  // R6 five minus three
        '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd6},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd7},
        '{OP_TK, 2'd0, 8'h01, 8'd1,  4'd7},
        '{OP_OUT,2'd0, 8'h00, 8'h06, 4'd7},  // R7 low at count 1
        '{OP_TK, 2'd0, 8'h01, 8'd1,  4'd7},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd7},
        '{OP_WR, 2'd3, 8'h56, 8'h00, 4'd3},  // R3 ch1 high-only, square
        '{OP_WR, 2'd1, 8'h02, 8'h00, 4'd3},
        '{OP_RD, 2'd1, 8'h00, 8'h02, 4'd3},
        '{OP_RD, 2'd1, 8'h00, 8'h02, 4'd4},  // R4 single byte repeats
        '{OP_WR, 2'd3, 8'hA6, 8'h00, 4'd3},  // ch2 low-only, square
        '{OP_WR, 2'd2, 8'h03, 8'h00, 4'd3},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd8},
        '{OP_TK, 2'd0, 8'h04, 8'd3,  4'd8},
        '{OP_OUT,2'd0, 8'h00, 8'h03, 4'd8},  // R8 first reload low
        '{OP_RD, 2'd2, 8'h00, 8'h03, 4'd7},  // reloaded value
        '{OP_TK, 2'd0, 8'h04, 8'd3,  4'd8},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd8},
        '{OP_RD, 2'd3, 8'h00, 8'hFF, 4'd5},  // R5
        '{OP_TK, 2'd0, 8'h01, 8'd1,  4'd9},
        '{OP_WR, 2'd3, 8'h00, 8'h00, 4'd9},  // R9 latch ch0 at 4
        '{OP_TK, 2'd0, 8'h01, 8'd2,  4'd9},
        '{OP_RD, 2'd0, 8'h00, 8'h04, 4'd9},
        '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd9},
        '{OP_RD, 2'd0, 8'h00, 8'h02, 4'd9},  // live after full read
        '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd9},
        '{OP_TK, 2'd0, 8'h01, 8'd1,  4'd9},
        '{OP_OUT,2'd0, 8'h00, 8'h06, 4'd9},  // mode kept by latch
        '{OP_TK, 2'd0, 8'h01, 8'd1,  4'd7},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd7},
        '{OP_WR, 2'd3, 8'hF4, 8'h00, 4'd1},  // R1 select 3 ignored
        '{OP_RD, 2'd0, 8'h00, 8'h05, 4'd1},
        '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd1},
        '{OP_WR, 2'd3, 8'h70, 8'h00, 4'd11}, // R11 ch1 mode 0
        '{OP_WR, 2'd1, 8'h04, 8'h00, 4'd11},
        '{OP_WR, 2'd1, 8'h00, 8'h00, 4'd11},
        '{OP_TK, 2'd0, 8'h02, 8'd3,  4'd11},
        '{OP_RD, 2'd1, 8'h00, 8'h04, 4'd11},
        '{OP_RD, 2'd1, 8'h00, 8'h00, 4'd11},
        '{OP_OUT,2'd0, 8'h00, 8'h07, 4'd11}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1 check(req, rdata, exp);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_tick(input logic [2:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_en = m;
            @(negedge clk); cnt_en = 3'b000;
        end
    endtask

    task automatic do_out(input logic [2:0] exp, input int req);
        @(negedge clk);
        check(req, {5'd0, tout}, {5'd0, exp});
    endtask

    initial begin
        rst = 1'b1; addr = 2'd0; wdata = 8'h00; wr_stb = 1'b0; rd_stb = 1'b0;
        cnt_en = 3'b000; gate = 3'b111;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        do_out(3'b111, 10);
        do_rd(2'd0, 8'h00, 10);
        do_rd(2'd0, 8'h00, 10);
        do_rd(2'd3, 8'hFF, 5);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                OP_WR:   do_wr(VEC[v].a, VEC[v].d);
                OP_RD:   do_rd(VEC[v].a, VEC[v].e, int'(VEC[v].req));
                OP_TK:   do_tick(VEC[v].d[2:0], int'(VEC[v].e));
                default: do_out(VEC[v].e[2:0], int'(VEC[v].req));
            endcase
        end

        // R6 gate low blocks counting (ch0 holds 5)
        gate = 3'b110;
        do_tick(3'b001, 3);
        do_rd(2'd0, 8'h05, 6);
        do_rd(2'd0, 8'h00, 6);
        gate = 3'b111;

        // R2 no counting before second byte
        do_wr(2'd3, 8'h34);
        do_wr(2'd0, 8'h02);
        do_tick(3'b001, 3);
        do_rd(2'd0, 8'h05, 2);
        do_rd(2'd0, 8'h00, 2);
        do_wr(2'd0, 8'h00);
        do_rd(2'd0, 8'h02, 2);
        do_rd(2'd0, 8'h00, 2);
        do_tick(3'b001, 1);
        do_out(3'b110, 7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule